// File: doc/BRIEF.md
# Multi-Destination Interrupt Aggregator

This block collects a wide vector of level-sensitive, active-high interrupt lines and presents them to software as three 32-bit banks. Each line has a latched pending bit, an enable bit and a per-destination routing bit. Software enables lines through dedicated write-one-to-set and write-one-to-clear locations, so no read-modify-write of the mask is ever needed. It acknowledges pending bits by writing ones to the pending location. Nine destination outputs each raise whenever any line that is pending, enabled and routed to them is active.

A plain 32-bit register port gives access: a write strobe, a byte address and write data, with read data returned combinationally for the address presented. The default build has 86 lines, so only bits 0 to 21 of the third bank exist. For each destination and bank, a read-only identify location shows which routed lines are asserting that destination. It has no state machine: every register updates on the rising clock edge from its own write strobe and the line inputs.

Top module: `irqagg_ctrl`

## Requirements
- R1: After reset, every pending, enable and routing bit reads zero and all nine destination outputs are low.
- R2: A pending bit becomes one at the first clock edge where its line is high, and it stays one after the line falls until it is acknowledged. Pending bits of bank b read at 0x30+4b.
- R3: Writing to a pending location clears every bit written as one and leaves bits written as zero unchanged. If a line is high on the same edge as its acknowledge, its pending bit stays one.
- R4: Writing to 0x60+4b sets the enable bits of bank b that are written as one and leaves the others unchanged. The enable mask reads back at 0x48+4b, and writes to that readback location are ignored.
- R5: Writing to 0x54+4b clears the enable bits of bank b that are written as one and leaves the others unchanged.
- R6: The routing word of bank b for destination n (0..8) is read/write at 0x78+0x24b+4n. Bit i set routes line 32b+i to destination n.
- R7: The identify word of bank b for destination n reads at 0xE4+0x24b+4n and equals pending AND enable AND routing. Writes to it are ignored.
- R8: Destination output n is high exactly when any identify bit for n, in any bank, is one.
- R9: Bits of the last bank beyond the number of lines (bits 22..31 of bank 2 by default) always read zero in every register.
- R10: Reads of any offset not listed above return zero, and writes there change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src_i | input | NUM_SRC (86) | Level-sensitive, active-high interrupt lines |
| bus_we_i | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr_i | input | ADDR_W (9) | Byte address of the access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| dest_irq_o | output | NUM_DEST (9) | Destination interrupt outputs |

## Verification
Every register result is due at the first rising edge after its cause. A line that is high, or a write, at edge k shows in the read data and on the destination outputs straight after edge k, because both are combinational from the registers. Each step of the bench drives its stimulus at a falling edge and lets one rising edge pass. It then moves the address to the location under test and samples read data and outputs two time units later, well before the next edge. The same-edge case of acknowledge and active line is driven in one step, so it sees the one edge where set and clear compete.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    // Register locations (byte offsets); software decodes these, so they are fixed.
    localparam int unsigned PEND_BASE   = 32'h30;
    localparam int unsigned EN_RD_BASE  = 32'h48;
    localparam int unsigned EN_CLR_BASE = 32'h54;
    localparam int unsigned EN_SET_BASE = 32'h60;
    localparam int unsigned ROUTE_BASE  = 32'h78;
    localparam int unsigned IDENT_BASE  = 32'hE4;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_PEND,
        RK_EN_RD,
        RK_EN_CLR,
        RK_EN_SET,
        RK_ROUTE,
        RK_IDENT
    } reg_kind_e;

endpackage

// File: rtl/irqagg_decode.sv
module irqagg_decode
    import irqagg_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    parameter int NUM_DEST  = 9,
    parameter int ADDR_W    = 9,
    localparam int BIDX_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int DIDX_W   = (NUM_DEST > 1) ? $clog2(NUM_DEST) : 1
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_kind_e         kind_o,
    output logic [BIDX_W-1:0] bank_o,
    output logic [DIDX_W-1:0] dest_o
);

    localparam int unsigned BANK_STRIDE = 4 * NUM_DEST;

    int unsigned a;

    always_comb begin
        a      = 32'(addr_i);
        kind_o = RK_NONE;
        bank_o = '0;
        dest_o = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (a == PEND_BASE + 4 * b) begin
                kind_o = RK_PEND;
                bank_o = BIDX_W'(b);
            end
            if (a == EN_RD_BASE + 4 * b) begin
                kind_o = RK_EN_RD;
                bank_o = BIDX_W'(b);
            end
            if (a == EN_CLR_BASE + 4 * b) begin
                kind_o = RK_EN_CLR;
                bank_o = BIDX_W'(b);
            end
            if (a == EN_SET_BASE + 4 * b) begin
                kind_o = RK_EN_SET;
                bank_o = BIDX_W'(b);
            end
            for (int d = 0; d < NUM_DEST; d++) begin
                if (a == ROUTE_BASE + BANK_STRIDE * b + 4 * d) begin
                    kind_o = RK_ROUTE;
                    bank_o = BIDX_W'(b);
                    dest_o = DIDX_W'(d);
                end
                if (a == IDENT_BASE + BANK_STRIDE * b + 4 * d) begin
                    kind_o = RK_IDENT;
                    bank_o = BIDX_W'(b);
                    dest_o = DIDX_W'(d);
                end
            end
        end
    end

endmodule

// File: rtl/irqagg_bank.sv
module irqagg_bank #(
    parameter int BANK_W     = 32,
    parameter int VALID_BITS = 32,
    parameter int NUM_DEST   = 9
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [BANK_W-1:0]                src_i,
    input  logic [BANK_W-1:0]                wdata_i,
    input  logic                             ack_we_i,
    input  logic                             set_we_i,
    input  logic                             clr_we_i,
    input  logic [NUM_DEST-1:0]              route_we_i,
    output logic [BANK_W-1:0]                pend_q,
    output logic [BANK_W-1:0]                en_q,
    output logic [NUM_DEST-1:0][BANK_W-1:0]  route_q,
    output logic [NUM_DEST-1:0][BANK_W-1:0]  ident_o
);

    logic [BANK_W-1:0] valid_mask;
    logic [BANK_W-1:0] ack_bits;

    for (genvar i = 0; i < BANK_W; i++) begin : g_mask
        assign valid_mask[i] = (i < VALID_BITS);
    end

    assign ack_bits = ack_we_i ? wdata_i : '0;

    // Pending: an active line wins over an acknowledge on the same edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= ((pend_q & ~ack_bits) | src_i) & valid_mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (set_we_i) begin
            en_q <= (en_q | wdata_i) & valid_mask;
        end else if (clr_we_i) begin
            en_q <= en_q & ~wdata_i;
        end
    end

    for (genvar d = 0; d < NUM_DEST; d++) begin : g_route
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                route_q[d] <= '0;
            end else if (route_we_i[d]) begin
                route_q[d] <= wdata_i & valid_mask;
            end
        end
        assign ident_o[d] = pend_q & en_q & route_q[d];
    end

endmodule

// File: rtl/irqagg_ctrl.sv
module irqagg_ctrl
    import irqagg_pkg::*;
#(
    parameter int NUM_SRC  = 86,
    parameter int BANK_W   = 32,
    parameter int NUM_DEST = 9,
    parameter int ADDR_W   = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  irq_src_i,
    input  logic                bus_we_i,
    input  logic [ADDR_W-1:0]   bus_addr_i,
    input  logic [BANK_W-1:0]   bus_wdata_i,
    output logic [BANK_W-1:0]   bus_rdata_o,
    output logic [NUM_DEST-1:0] dest_irq_o
);

    localparam int NUM_BANKS = (NUM_SRC + BANK_W - 1) / BANK_W;
    localparam int SRC_PAD   = NUM_BANKS * BANK_W;
    localparam int BIDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
    localparam int DIDX_W    = (NUM_DEST > 1) ? $clog2(NUM_DEST) : 1;

    reg_kind_e         dec_kind;
    logic [BIDX_W-1:0] dec_bank;
    logic [DIDX_W-1:0] dec_dest;

    logic [SRC_PAD-1:0] src_pad;
    logic [SRC_PAD-1:0] pend_pad;
    logic [SRC_PAD-1:0] en_pad;
    logic [NUM_DEST*SRC_PAD-1:0] route_pad;

    logic [BANK_W-1:0]               pend_b  [NUM_BANKS];
    logic [BANK_W-1:0]               en_b    [NUM_BANKS];
    logic [NUM_DEST-1:0][BANK_W-1:0] route_b [NUM_BANKS];
    logic [NUM_DEST-1:0][BANK_W-1:0] ident_b [NUM_BANKS];

    assign src_pad = SRC_PAD'(irq_src_i);

    irqagg_decode #(
        .NUM_BANKS (NUM_BANKS),
        .NUM_DEST  (NUM_DEST),
        .ADDR_W    (ADDR_W)
    ) u_decode (
        .addr_i (bus_addr_i),
        .kind_o (dec_kind),
        .bank_o (dec_bank),
        .dest_o (dec_dest)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int REMAIN = NUM_SRC - b * BANK_W;
        localparam int VBITS  = (REMAIN >= BANK_W) ? BANK_W : REMAIN;

        logic               hit;
        logic [NUM_DEST-1:0] route_we;

        assign hit = bus_we_i && (dec_bank == BIDX_W'(b));

        for (genvar d = 0; d < NUM_DEST; d++) begin : g_rwe
            assign route_we[d] = hit && (dec_kind == RK_ROUTE) &&
                                 (dec_dest == DIDX_W'(d));
        end

        irqagg_bank #(
            .BANK_W     (BANK_W),
            .VALID_BITS (VBITS),
            .NUM_DEST   (NUM_DEST)
        ) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .src_i      (src_pad[b*BANK_W +: BANK_W]),
            .wdata_i    (bus_wdata_i),
            .ack_we_i   (hit && (dec_kind == RK_PEND)),
            .set_we_i   (hit && (dec_kind == RK_EN_SET)),
            .clr_we_i   (hit && (dec_kind == RK_EN_CLR)),
            .route_we_i (route_we),
            .pend_q     (pend_b[b]),
            .en_q       (en_b[b]),
            .route_q    (route_b[b]),
            .ident_o    (ident_b[b])
        );

        assign pend_pad[b*BANK_W +: BANK_W] = pend_b[b];
        assign en_pad[b*BANK_W +: BANK_W]   = en_b[b];
        for (genvar d = 0; d < NUM_DEST; d++) begin : g_rflat
            assign route_pad[d*SRC_PAD + b*BANK_W +: BANK_W] = route_b[b][d];
        end
    end

    always_comb begin
        unique case (dec_kind)
            RK_PEND:   bus_rdata_o = pend_b[dec_bank];
            RK_EN_RD:  bus_rdata_o = en_b[dec_bank];
            RK_ROUTE:  bus_rdata_o = route_b[dec_bank][dec_dest];
            RK_IDENT:  bus_rdata_o = ident_b[dec_bank][dec_dest];
            default:   bus_rdata_o = '0;
        endcase
    end

    always_comb begin
        dest_irq_o = '0;
        for (int d = 0; d < NUM_DEST; d++) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                dest_irq_o[d] = dest_irq_o[d] | (|ident_b[b][d]);
            end
        end
    end

endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk #(
    parameter int SRC_PAD  = 96,
    parameter int NUM_DEST = 9
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        bus_we_i,
    input logic [SRC_PAD-1:0]          src_pad,
    input logic [SRC_PAD-1:0]          pend_pad,
    input logic [SRC_PAD-1:0]          en_pad,
    input logic [NUM_DEST*SRC_PAD-1:0] route_pad,
    input logic [NUM_DEST-1:0]         dest_irq_o
);

    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (dest_irq_o == '0 && pend_pad == '0 && en_pad == '0));

    p_line_latches_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_pad & $past(src_pad)) == $past(src_pad)));

    p_no_spurious_pend_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_pad & ~$past(pend_pad) & ~$past(src_pad)) == '0));

    p_enable_needs_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we_i |=> $stable(en_pad));

    p_route_needs_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we_i |=> $stable(route_pad));

    p_dest_needs_enabled_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dest_irq_o != '0) |-> ((pend_pad & en_pad) != '0));

endmodule

bind irqagg_ctrl irqagg_chk #(
    .SRC_PAD  (SRC_PAD),
    .NUM_DEST (NUM_DEST)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we_i   (bus_we_i),
    .src_pad    (src_pad),
    .pend_pad   (pend_pad),
    .en_pad     (en_pad),
    .route_pad  (route_pad),
    .dest_irq_o (dest_irq_o)
);

// File: tb/irqagg_ctrl_tb.sv
module irqagg_ctrl_tb;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [31:0] src0;
        logic        we;
        logic [8:0]  waddr;
        logic [31:0] wdata;
        logic [8:0]  raddr;
        logic [31:0] exp_rd;
        logic [8:0]  exp_dest;
        logic [7:0]  req;
    } step_t;

    localparam int NSTEP = 13;
    localparam step_t TBL [NSTEP] = '{
        '{32'h0, 1'b0, 9'h000, 32'h0,        9'h030, 32'h0, 9'h000, 8'd2},  // R2 idle
        '{32'h5, 1'b0, 9'h000, 32'h0,        9'h030, 32'h5, 9'h000, 8'd2},  // R2 latch
        '{32'h0, 1'b1, 9'h060, 32'h1,        9'h048, 32'h1, 9'h000, 8'd4},  // R4 set
        '{32'h0, 1'b1, 9'h084, 32'h3,        9'h084, 32'h3, 9'h008, 8'd6},  // R6 route d3
        '{32'h0, 1'b0, 9'h000, 32'h0,        9'h0F0, 32'h1, 9'h008, 8'd7},  // R7 ident d3
        '{32'h0, 1'b1, 9'h060, 32'h4,        9'h0F0, 32'h1, 9'h008, 8'd4},  // R4 set keeps
        '{32'h0, 1'b1, 9'h078, 32'h4,        9'h0E4, 32'h4, 9'h009, 8'd8},  // R8 two dests
        '{32'h0, 1'b1, 9'h030, 32'h1,        9'h030, 32'h4, 9'h001, 8'd3},  // R3 ack
        '{32'h0, 1'b1, 9'h054, 32'h4,        9'h048, 32'h1, 9'h000, 8'd5},  // R5 clear
        '{32'h1, 1'b1, 9'h030, 32'h1,        9'h030, 32'h5, 9'h008, 8'd3},  // R3 set wins
        '{32'h0, 1'b1, 9'h0F0, 32'hFFFFFFFF, 9'h0F0, 32'h1, 9'h008, 8'd7},  // R7 ro
        '{32'h0, 1'b1, 9'h040, 32'hFFFFFFFF, 9'h040, 32'h0, 9'h008, 8'd10}, // R10 hole
        '{32'h0, 1'b1, 9'h048, 32'hFFFFFFFF, 9'h048, 32'h1, 9'h008, 8'd4}   // R4 rd-only
    };

    logic        clk;
    logic        rst_n;
    logic [85:0] src;
    logic        we;
    logic [8:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic [8:0]  dest;

    int total;
    int bad;
    bit finished;

    irqagg_ctrl u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_src_i   (src),
        .bus_we_i    (we),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .dest_irq_o  (dest)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive at the falling edge, let one rising edge pass, then present raddr.
    task automatic step(input logic w, input logic [8:0] wa, input logic [31:0] wd,
                        input logic [8:0] ra);
        @(negedge clk);
        we    = w;
        addr  = wa;
        wdata = wd;
        @(posedge clk);
        #1;
        we   = 1'b0;
        addr = ra;
        #1;
    endtask

    task automatic peek(input logic [8:0] ra);
        @(negedge clk);
        addr = ra;
        #1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        total = 0;
        bad = 0;
        finished = 1'b0;
        rst_n = 1'b0;
        src   = '0;
        we    = 1'b0;
        addr  = '0;
        wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        peek(9'h030); check("R1 pend", rdata, 32'h0);
        peek(9'h048); check("R1 enable", rdata, 32'h0);
        peek(9'h0C0); check("R1 route", rdata, 32'h0);
        check("R1 dest", 32'(dest), 32'h0);

        for (int i = 0; i < NSTEP; i++) begin
            src = 86'(TBL[i].src0);
            step(TBL[i].we, TBL[i].waddr, TBL[i].wdata, TBL[i].raddr);
            check($sformatf("R%0d step%0d rdata", TBL[i].req, i), rdata, TBL[i].exp_rd);
            check($sformatf("R%0d step%0d dest", TBL[i].req, i), 32'(dest),
                  32'(TBL[i].exp_dest));
        end

        // R9: last bank only holds 22 real bits
        src = '1;
        step(1'b1, 9'h068, 32'hFFFFFFFF, 9'h050);
        check("R9 enable bank2", rdata, 32'h003FFFFF);
        peek(9'h038); check("R9 pend bank2", rdata, 32'h003FFFFF);
        step(1'b1, 9'h0E0, 32'hFFFFFFFF, 9'h0E0);
        check("R9 route bank2 d8", rdata, 32'h003FFFFF);
        check("R8 dest with bank2", 32'(dest), 32'h108);
        peek(9'h14C); check("R7 ident bank2 d8", rdata, 32'h003FFFFF);

        // R6 bank1 routing to destination 5
        step(1'b1, 9'h064, 32'h80000000, 9'h04C);
        check("R4 enable bank1", rdata, 32'h80000000);
        step(1'b1, 9'h0B0, 32'h80000000, 9'h11C);
        check("R6 ident bank1 d5", rdata, 32'h80000000);
        check("R8 dest bank1", 32'(dest), 32'h128);

        // R5 clear on bank1 drops destination 5
        step(1'b1, 9'h058, 32'hFFFFFFFF, 9'h04C);
        check("R5 clear bank1", rdata, 32'h0);
        check("R5 dest after clear", 32'(dest), 32'h108);

        // R1 reset in mid-run
        @(negedge clk);
        src   = '0;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        peek(9'h030); check("R1 pend after reset", rdata, 32'h0);
        peek(9'h050); check("R1 enable after reset", rdata, 32'h0);
        peek(9'h084); check("R1 route after reset", rdata, 32'h0);
        check("R1 dest after reset", 32'(dest), 32'h0);

        finish_run();
    end

endmodule